// File: doc/BRIEF.md
# Stereo Soft Mute with Zero-Run Automute

This block sits in a stereo audio sample path, one stereo sample per strobe. It scales both channels by a shared gain that moves one step per sample strobe, so muting fades the signal to silence over a set number of samples and unmuting fades it back up at the same rate. No sample is cut off abruptly.

A three-way mute control decides whether the gain heads down or up. Driven low means play and driven high means mute. A floating control hands the decision to a zero-run detector. That detector counts consecutive stereo samples in which both channels are exactly zero. Once the run reaches a threshold, it sets an automute latch. Any non-zero sample on either channel clears the latch. The latch is always visible on a status output, whichever way the control is set, so other logic can use it.

The gain moves through a four-state machine. `ST_PLAY` holds full gain. `ST_DUCK` ramps the gain down. `ST_QUIET` holds zero gain. `ST_RISE` ramps the gain up. The transitions are:
- PLAY→DUCK on a mute request.
- DUCK→QUIET when the gain reaches zero.
- DUCK→RISE when the request drops.
- QUIET→RISE on release.
- RISE→PLAY when the gain reaches full.
- RISE→DUCK on a new request.
- When a single step covers the whole span, PLAY→QUIET and QUIET→PLAY are taken directly.

Top module: `stereo_soft_mute`

## Requirements
- R1: After reset the gain equals GAIN_MAX = 2^RAMP_LOG2, the automute flag is 0, `out_valid` is 0 and both output samples are 0.
- R2: `mute_ctl` encoding: 2'b00 means driven low (play), 2'b01 means driven high (mute request), and 2'b10 or 2'b11 means floating (automute decides). A mute request lowers the gain by one on each strobe until it reaches 0, where it stays.
- R3: On the strobe that completes ZERO_LIMIT consecutive samples with both channels zero, the automute flag goes to 1 in the following cycle. With fewer zero samples than that, it stays 0.
- R4: A strobe with either channel non-zero clears the automute flag in the following cycle and restarts the zero count from 0.
- R5: With `mute_ctl` driven low, a set automute flag has no effect, and the gain keeps rising toward GAIN_MAX or holds there.
- R6: The gain changes only on a strobe, by exactly one step, and is clamped to the range 0..GAIN_MAX. Without a request it rises by one per strobe, at the same rate it falls. A reversal in mid-ramp turns it around on the next strobe.
- R7: One cycle after a strobe, `out_valid` is 1 and each output equals floor(sample × g / GAIN_MAX). Here g is the gain before that strobe's update. The mute decision of a strobe uses the flag value from before that strobe.
- R8: The automute flag is driven on `automuted` whatever the value of `mute_ctl`.
- R9: With `mute_ctl` floating, a set flag requests mute and a clear flag releases it.
- R10: The zero counter saturates at ZERO_LIMIT, so an arbitrarily long zero run keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Strobe: one stereo sample present |
| smp_left | input | DATA_W | Left sample, two's complement |
| smp_right | input | DATA_W | Right sample, two's complement |
| mute_ctl | input | 2 | 00 play, 01 mute, 1x floating (auto) |
| out_valid | output | 1 | Scaled sample present |
| out_left | output | DATA_W | Scaled left sample |
| out_right | output | DATA_W | Scaled right sample |
| automuted | output | 1 | Zero-run latch state |
| gain | output | RAMP_LOG2+1 | Current gain, 0..GAIN_MAX |

## Verification
Every result of the block appears one register after the strobe that causes it. The scaled samples, `out_valid`, the new gain and the new flag value all appear in the cycle after the strobe. The bench drives a strobe on a falling edge, drops it on the next falling edge, and samples every output at that moment, after exactly one rising edge. For the zero-run cases, the bench expects the flag on the sample right after the strobe that completes the run, and checks that the gain holds still for that same strobe. The bench also checks that the gain starts to fall only on the following strobe, because each mute decision uses the flag value from before its own strobe.

// File: rtl/smz_pkg.sv
package smz_pkg;
    typedef enum logic [1:0] {
        MM_PLAY  = 2'b00,
        MM_MUTE  = 2'b01,
        MM_AUTO  = 2'b10,
        MM_AUTO2 = 2'b11
    } mute_mode_e;

    typedef enum logic [1:0] {
        ST_PLAY  = 2'b00,
        ST_DUCK  = 2'b01,
        ST_QUIET = 2'b10,
        ST_RISE  = 2'b11
    } ramp_state_e;
endpackage

// File: rtl/smz_zero_detect.sv
module smz_zero_detect #(
    parameter int DATA_W     = 24,
    parameter int ZERO_LIMIT = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [DATA_W-1:0] left,
    input  logic [DATA_W-1:0] right,
    output logic              latched
);
    localparam int CNT_W = $clog2(ZERO_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ZERO_LIMIT);

    logic [CNT_W-1:0] run_cnt;
    logic             both_zero;

    assign both_zero = (left == '0) && (right == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            latched <= 1'b0;
        end else if (strobe) begin
            if (!both_zero) begin
                run_cnt <= '0;
                latched <= 1'b0;
            end else if (run_cnt != LIMIT) begin
                run_cnt <= run_cnt + 1'b1;
                if (run_cnt == LIMIT - 1'b1) latched <= 1'b1;
            end
        end
    end

    assert_latch_set_on_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched) |-> $past(strobe && both_zero && run_cnt == LIMIT - 1'b1));

    assert_latch_clear_on_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !both_zero) |=> (!latched && run_cnt == '0));

    assert_count_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= LIMIT);
endmodule

// File: rtl/smz_ramp_fsm.sv
module smz_ramp_fsm
    import smz_pkg::*;
#(
    parameter int RAMP_LOG2 = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strobe,
    input  logic [1:0]           mute_ctl,
    input  logic                 auto_flag,
    output logic [RAMP_LOG2:0]   gain
);
    localparam int GW = RAMP_LOG2 + 1;
    localparam logic [GW-1:0] GAIN_MAX = GW'(1) << RAMP_LOG2;

    ramp_state_e      state, state_nx;
    logic [GW-1:0]    gain_nx;
    logic             req;
    logic [GW-1:0]    dn_val, up_val;
    mute_mode_e       mode;

    assign mode   = mute_mode_e'(mute_ctl);
    assign dn_val = (gain == '0) ? '0 : gain - 1'b1;
    assign up_val = (gain == GAIN_MAX) ? GAIN_MAX : gain + 1'b1;

    always_comb begin
        unique case (mode)
            MM_PLAY:          req = 1'b0;
            MM_MUTE:          req = 1'b1;
            MM_AUTO, MM_AUTO2: req = auto_flag;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PLAY;
            gain  <= GAIN_MAX;
        end else begin
            state <= state_nx;
            gain  <= gain_nx;
        end
    end

    always_comb begin
        state_nx = state;
        gain_nx  = gain;
        if (strobe) begin
            unique case (state)
                ST_PLAY: if (req) begin
                    gain_nx  = dn_val;
                    state_nx = (dn_val == '0) ? ST_QUIET : ST_DUCK;
                end
                ST_QUIET: if (!req) begin
                    gain_nx  = up_val;
                    state_nx = (up_val == GAIN_MAX) ? ST_PLAY : ST_RISE;
                end
                ST_DUCK, ST_RISE: begin
                    if (req) begin
                        gain_nx  = dn_val;
                        state_nx = (dn_val == '0) ? ST_QUIET : ST_DUCK;
                    end else begin
                        gain_nx  = up_val;
                        state_nx = (up_val == GAIN_MAX) ? ST_PLAY : ST_RISE;
                    end
                end
            endcase
        end
    end

    assert_hold_without_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(gain));

    assert_low_overrides_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && mute_ctl == 2'b00 && gain != GAIN_MAX) |=> gain == $past(gain) + 1'b1);

    assert_mute_steps_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && mute_ctl == 2'b01 && gain != '0) |=> gain == $past(gain) - 1'b1);

    assert_gain_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gain <= GAIN_MAX);
endmodule

// File: rtl/smz_scale.sv
module smz_scale #(
    parameter int DATA_W    = 24,
    parameter int RAMP_LOG2 = 7
) (
    input  logic [DATA_W-1:0]  sample,
    input  logic [RAMP_LOG2:0] gain,
    output logic [DATA_W-1:0]  scaled
);
    localparam int GW = RAMP_LOG2 + 1;
    localparam int PW = DATA_W + GW + 1;

    logic signed [PW-1:0] s_ext, g_ext, prod;

    always_comb begin
        s_ext  = {{(PW-DATA_W){sample[DATA_W-1]}}, sample};
        g_ext  = {{(PW-GW){1'b0}}, gain};
        prod   = s_ext * g_ext;
        scaled = DATA_W'(prod >>> RAMP_LOG2);
    end
endmodule

// File: rtl/stereo_soft_mute.sv
module stereo_soft_mute #(
    parameter int DATA_W     = 24,
    parameter int ZERO_LIMIT = 1024,
    parameter int RAMP_LOG2  = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic [DATA_W-1:0]    smp_left,
    input  logic [DATA_W-1:0]    smp_right,
    input  logic [1:0]           mute_ctl,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_left,
    output logic [DATA_W-1:0]    out_right,
    output logic                 automuted,
    output logic [RAMP_LOG2:0]   gain
);
    localparam int NCH = 2;

    logic [DATA_W-1:0] ch_in  [NCH];
    logic [DATA_W-1:0] ch_out [NCH];
    logic              flag;

    assign ch_in[0]  = smp_left;
    assign ch_in[1]  = smp_right;
    assign automuted = flag;

    smz_zero_detect #(.DATA_W(DATA_W), .ZERO_LIMIT(ZERO_LIMIT)) u_zero (
        .clk(clk), .rst_n(rst_n), .strobe(smp_valid),
        .left(smp_left), .right(smp_right), .latched(flag)
    );

    smz_ramp_fsm #(.RAMP_LOG2(RAMP_LOG2)) u_ramp (
        .clk(clk), .rst_n(rst_n), .strobe(smp_valid),
        .mute_ctl(mute_ctl), .auto_flag(flag), .gain(gain)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        smz_scale #(.DATA_W(DATA_W), .RAMP_LOG2(RAMP_LOG2)) u_scale (
            .sample(ch_in[c]), .gain(gain), .scaled(ch_out[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= smp_valid;
            if (smp_valid) begin
                out_left  <= ch_out[0];
                out_right <= ch_out[1];
            end
        end
    end

    assert_silent_at_zero_gain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && gain == '0) |=> (out_valid && out_left == '0 && out_right == '0));

    assert_full_gain_passes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && gain == (1 << RAMP_LOG2)) |=> (out_left == $past(smp_left)));

    assert_auto_requests_mute_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && mute_ctl[1] && automuted && gain != '0) |=> gain == $past(gain) - 1'b1);
endmodule

// File: tb/stereo_soft_mute_bench.sv
module stereo_soft_mute_bench;
    localparam int DW = 24;
    localparam int ZL = 8;
    localparam int RL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_left = '0, smp_right = '0;
    logic [1:0]    mute_ctl = 2'b00;
    logic          out_valid, automuted;
    logic [DW-1:0] out_left, out_right;
    logic [RL:0]   gain;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    stereo_soft_mute #(.DATA_W(DW), .ZERO_LIMIT(ZL), .RAMP_LOG2(RL)) u_stereo_soft_mute (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_left(smp_left),
        .smp_right(smp_right), .mute_ctl(mute_ctl), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right), .automuted(automuted), .gain(gain)
    );

    typedef struct packed {
        logic [1:0]          ctl;
        logic signed [23:0]  l;
        logic signed [23:0]  r;
        logic signed [23:0]  el;
        logic signed [23:0]  er;
        logic [2:0]          eg;
    } vec_t;

    localparam vec_t VEC [14] = '{
        '{2'b00, 24'sd400, -24'sd400, 24'sd400, -24'sd400, 3'd4},
        '{2'b01, 24'sd400, -24'sd400, 24'sd400, -24'sd400, 3'd3},
        '{2'b01, 24'sd400, -24'sd400, 24'sd300, -24'sd300, 3'd2},
        '{2'b01, 24'sd400, -24'sd400, 24'sd200, -24'sd200, 3'd1},
        '{2'b01, 24'sd400, -24'sd400, 24'sd100, -24'sd100, 3'd0},
        '{2'b01, 24'sd400, -24'sd400, 24'sd0,   24'sd0,    3'd0},
        '{2'b00, 24'sd400, -24'sd400, 24'sd0,   24'sd0,    3'd1},
        '{2'b00, 24'sd400, -24'sd400, 24'sd100, -24'sd100, 3'd2},
        '{2'b01, 24'sd400, -24'sd400, 24'sd200, -24'sd200, 3'd1},
        '{2'b00, 24'sd400, -24'sd400, 24'sd100, -24'sd100, 3'd2},
        '{2'b00, 24'sd400, -24'sd400, 24'sd200, -24'sd200, 3'd3},
        '{2'b00, 24'sd400, -24'sd400, 24'sd300, -24'sd300, 3'd4},
        '{2'b00, 24'sd7,   -24'sd7,   24'sd7,   -24'sd7,   3'd4},
        '{2'b11, 24'sd5,   24'sd0,    24'sd5,   24'sd0,    3'd4}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] ctl, input int l, input int r);
        @(negedge clk);
        mute_ctl  = ctl;
        smp_left  = DW'(l);
        smp_right = DW'(r);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 gain", int'(gain), 4);
        check("R1 flag", int'(automuted), 0);
        check("R1 valid", int'(out_valid), 0);
        check("R1 out", int'(signed'(out_left)), 0);
        rst_n = 1'b1;

        // R2/R6/R7 table walk: ramp down, hold, ramp up, reversal, floor
        for (int i = 0; i < 14; i++) begin
            send(VEC[i].ctl, int'(VEC[i].l), int'(VEC[i].r));
            check("R7 valid", int'(out_valid), 1);
            check("R7 left", int'(signed'(out_left)), int'(VEC[i].el));
            check("R7 right", int'(signed'(out_right)), int'(VEC[i].er));
            check("R6 gain", int'(gain), int'(VEC[i].eg));
        end

        // R6 no strobe, no gain change
        @(negedge clk); mute_ctl = 2'b01;
        repeat (5) @(negedge clk);
        check("R6 hold", int'(gain), 4);
        check("R7 valid low", int'(out_valid), 0);

        // R3 run of ZL-1 zeros: flag stays clear
        for (int i = 0; i < ZL - 1; i++) send(2'b10, 0, 0);
        check("R3 short run", int'(automuted), 0);
        check("R9 no mute", int'(gain), 4);
        send(2'b10, 0, 0);
        check("R3 flag set", int'(automuted), 1);
        check("R7 decision uses old flag", int'(gain), 4);
        send(2'b10, 0, 0);
        check("R9 auto duck", int'(gain), 3);
        // R10 long zero run keeps flag set
        for (int i = 0; i < 20; i++) send(2'b10, 0, 0);
        check("R10 saturate flag", int'(automuted), 1);
        check("R9 quiet", int'(gain), 0);

        // R4 non-zero clears flag, floating releases
        send(2'b10, 0, 400);
        check("R4 flag clear", int'(automuted), 0);
        check("R4 out", int'(signed'(out_right)), 0);
        check("R4 gain", int'(gain), 0);
        send(2'b10, 0, 400);
        check("R9 release", int'(gain), 1);
        for (int i = 0; i < ZL - 1; i++) send(2'b10, 0, 0);
        check("R4 count restart", int'(automuted), 0);
        send(2'b10, 123, 0);
        for (int i = 0; i < 3; i++) send(2'b00, 1, 1);
        check("R6 back to full", int'(gain), 4);

        // R5/R8 low overrides latch; flag still exported
        for (int i = 0; i < ZL + 2; i++) send(2'b00, 0, 0);
        check("R8 flag visible", int'(automuted), 1);
        check("R5 no mute", int'(gain), 4);
        send(2'b01, 0, 0);
        check("R8 flag under mute", int'(automuted), 1);
        check("R2 mute step", int'(gain), 3);

        // R1 reset mid-operation
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 gain again", int'(gain), 4);
        check("R1 flag again", int'(automuted), 0);
        finish_run();
    end
endmodule